// File: doc/BRIEF.md
# Chassis Intrusion Tracker

This block keeps the history of chassis-open events reported by an already debounced enclosure switch. The history lives in retained, battery-backed storage outside the block: each cycle the block reads the stored fields on its `rd_*` ports and, whenever something must change, presents the full new contents on its `wr_*` ports with `wr_en` high so that the storage cell captures them at the next clock edge. The stored fields are a validity byte, a sticky "ever opened" flag, a "coin battery removed" flag, a total open counter and a counter of openings seen while main power was off.

A host reaches the block through a single-cycle command strobe carrying two parameter bytes. A history command always answers with the four history fields as they stood before the command, and its parameter bytes can also ask for the sticky flag alone to be cleared, or for the whole history to be wiped when a magic byte is given. A separate live command answers with the present switch level only. If the stored validity byte is wrong, the block initialises the storage in one cycle.

Top module: `chassis_intrusion_tracker`

## Requirements
- R1: When the storage is valid, each rising edge of `sw_open` adds one to the total count and sets the ever-opened flag. A level held high counts once, and the level present while `rst_n` is low is taken as the baseline, so it does not count as an opening.
- R2: A rising edge seen while `main_pwr` is low also adds one to the powered-off count. While `main_pwr` is high that count is unchanged.
- R3: Both counts are 8 bits wide and stay at 255 instead of wrapping.
- R4: A `coin_loss` pulse sets the coin-battery flag. That flag survives sticky-only clears and is reset only by a full clear.
- R5: A history command (`cmd_valid` with `cmd_live` low) raises `rsp_valid` for exactly one cycle, on the cycle after the strobe. `rsp_data[7:0]` carries the ever-opened flag, `[15:8]` the coin flag, `[23:16]` the total count and `[31:24]` the powered-off count, all taken before the command has any effect. Parameter bytes 0x00/0x00 change nothing.
- R6: A history command with `cmd_p0` equal to 0xCE zeroes both flags and both counts. An opening or coin pulse in the same cycle is applied after the clear.
- R7: A history command with `cmd_p1` non-zero and `cmd_p0` not 0xCE clears only the ever-opened flag. Both counts and the coin flag are kept.
- R8: When `rd_magic` is not 0xEC, the block writes zero to every history field and 0xEC to the validity byte in that same cycle, and any event in that cycle is dropped. A history response taken from invalid storage reads as all zeros.
- R9: A live command (`cmd_valid` with `cmd_live` high) answers on the next cycle with `rsp_data` equal to the `sw_open` level at the strobe, zero-extended, and it changes no stored field.
- R10: `wr_en` is low while `rst_n` is low, and it is also low in any cycle where no stored field would change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the non-retained logic |
| sw_open | input | 1 | Debounced enclosure switch, 1 = open |
| main_pwr | input | 1 | Main power present |
| coin_loss | input | 1 | Pulse: coin battery was found removed |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_live | input | 1 | 1 = live-status command, 0 = history command |
| cmd_p0 | input | 8 | First parameter byte (full-clear magic) |
| cmd_p1 | input | 8 | Second parameter byte (sticky clear when non-zero) |
| rsp_valid | output | 1 | Response valid, one cycle |
| rsp_data | output | 32 | Response word |
| rd_magic | input | 8 | Stored validity byte |
| rd_ever | input | 1 | Stored ever-opened flag |
| rd_coin | input | 1 | Stored coin-battery flag |
| rd_total | input | 8 | Stored total open count |
| rd_offcnt | input | 8 | Stored powered-off open count |
| wr_en | output | 1 | Storage write enable |
| wr_magic | output | 8 | Validity byte to store |
| wr_ever | output | 1 | Ever-opened flag to store |
| wr_coin | output | 1 | Coin-battery flag to store |
| wr_total | output | 8 | Total count to store |
| wr_offcnt | output | 8 | Powered-off count to store |

## Verification
The counting function is driven with three hundred separate openings. Main power is low on every third one, so the two counters move at different rates and only the total reaches 255; this tells correct per-counter gating apart from shared increments, and shows saturation apart from wrap. Separate patterns hold the switch high over many cycles, hold it high through reset, and line events up in the same cycle as a full clear or a corrupted validity byte, which separates edge detection from level detection and shows how an event is ordered against a clear. The two clear levels are each applied with the coin flag set and the counters non-zero, so that a too-wide or too-narrow clear shows up in the next query.

// File: rtl/cit_pkg.sv
// Package: shared constants and the per-cycle update action of the
// chassis intrusion tracker. Assumes byte-wide command parameters.
package cit_pkg;

    localparam int BYTE_W = 8;

    // What the command path asks the history update to do this cycle.
    typedef enum logic [1:0] {
        ACT_NONE       = 2'd0,
        ACT_INIT       = 2'd1,
        ACT_CLR_ALL    = 2'd2,
        ACT_CLR_STICKY = 2'd3
    } cit_act_e;

endpackage

// File: rtl/cit_edge.sv
// Module: rising-edge detector for the (already debounced) switch input.
// Assumes: the level present during reset is the baseline, so a switch
// that is open while reset is held does not produce an edge.
module cit_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);

    logic prev_q;

    // Track the previous level; reset loads the current level as baseline.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= lvl;
        else        prev_q <= lvl;
    end

    // Edge is present while the level is high and was low one cycle ago.
    always_comb rise = rst_n && lvl && !prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise)
        else $error("two consecutive rising edges reported"); // R1

endmodule

// File: rtl/cit_cmd_dec.sv
// Module: decodes the storage validity and the host command into one
// update action. Assumes invalid storage outranks every command.
module cit_cmd_dec
    import cit_pkg::*;
#(
    parameter logic [BYTE_W-1:0] CLR_MAGIC = 8'hCE
) (
    input  logic              store_ok,
    input  logic              cmd_valid,
    input  logic              cmd_live,
    input  logic [BYTE_W-1:0] cmd_p0,
    input  logic [BYTE_W-1:0] cmd_p1,
    output cit_act_e          act
);

    // Priority: initialise, full clear, sticky clear, nothing.
    always_comb begin
        act = ACT_NONE;
        if (!store_ok) begin
            act = ACT_INIT;
        end else if (cmd_valid && !cmd_live) begin
            if (cmd_p0 == CLR_MAGIC)  act = ACT_CLR_ALL;
            else if (cmd_p1 != '0)    act = ACT_CLR_STICKY;
        end
    end

endmodule

// File: rtl/cit_hist_next.sv
// Module: computes the next contents of the retained history from the
// stored contents, the update action and this cycle's events.
// Assumes: clears happen first and events after them, except during
// initialisation where events are dropped.
module cit_hist_next
    import cit_pkg::*;
#(
    parameter int              CNT_W       = 8,
    parameter logic [BYTE_W-1:0] VALID_MAGIC = 8'hEC
) (
    input  cit_act_e          act,
    input  logic              rise,
    input  logic              main_pwr,
    input  logic              coin_loss,
    input  logic [BYTE_W-1:0] rd_magic,
    input  logic              rd_ever,
    input  logic              rd_coin,
    input  logic [CNT_W-1:0]  rd_total,
    input  logic [CNT_W-1:0]  rd_offcnt,
    output logic [BYTE_W-1:0] nx_magic,
    output logic              nx_ever,
    output logic              nx_coin,
    output logic [CNT_W-1:0]  nx_total,
    output logic [CNT_W-1:0]  nx_offcnt,
    output logic              changed
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Increment that stops at the all-ones value.
    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == CNT_MAX) ? v : v + 1'b1;
    endfunction

    // Apply the clear action, then the events, to the stored fields.
    always_comb begin
        nx_magic  = rd_magic;
        nx_ever   = rd_ever;
        nx_coin   = rd_coin;
        nx_total  = rd_total;
        nx_offcnt = rd_offcnt;
        unique case (act)
            ACT_INIT: begin
                nx_magic  = VALID_MAGIC;
                nx_ever   = 1'b0;
                nx_coin   = 1'b0;
                nx_total  = '0;
                nx_offcnt = '0;
            end
            ACT_CLR_ALL: begin
                nx_ever   = 1'b0;
                nx_coin   = 1'b0;
                nx_total  = '0;
                nx_offcnt = '0;
            end
            ACT_CLR_STICKY: nx_ever = 1'b0;
            default: ;
        endcase
        if (act != ACT_INIT) begin
            if (rise) begin
                nx_ever  = 1'b1;
                nx_total = sat_inc(nx_total);
                if (!main_pwr) nx_offcnt = sat_inc(nx_offcnt);
            end
            if (coin_loss) nx_coin = 1'b1;
        end
    end

    // Flag any difference so that idle cycles do not write the storage.
    always_comb begin
        changed = (nx_magic != rd_magic) || (nx_ever != rd_ever) ||
                  (nx_coin != rd_coin) || (nx_total != rd_total) ||
                  (nx_offcnt != rd_offcnt);
    end

endmodule

// File: rtl/cit_resp.sv
// Module: registered response path. Captures either the history fields
// (as stored before the command) or the live switch level.
// Assumes one command per strobe; the response follows one cycle later.
module cit_resp
    import cit_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic               cmd_live,
    input  logic               sw_open,
    input  logic               store_ok,
    input  logic               rd_ever,
    input  logic               rd_coin,
    input  logic [CNT_W-1:0]   rd_total,
    input  logic [CNT_W-1:0]   rd_offcnt,
    output logic               rsp_valid,
    output logic [4*CNT_W-1:0] rsp_data
);

    localparam int RSP_W = 4 * CNT_W;

    logic [RSP_W-1:0] hist_word;

    // Pack the history in field order; invalid storage reads as zero.
    always_comb begin
        hist_word = '0;
        if (store_ok) begin
            hist_word = {rd_offcnt, rd_total,
                         {(CNT_W-1){1'b0}}, rd_coin,
                         {(CNT_W-1){1'b0}}, rd_ever};
        end
    end

    // Register the response for one cycle per command strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= cmd_valid;
            if (cmd_valid) begin
                rsp_data <= cmd_live ? RSP_W'(sw_open) : hist_word;
            end
        end
    end

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> rsp_valid)
        else $error("response missing after command"); // R5
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !rsp_valid)
        else $error("response without command"); // R5
    AST_LIVE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_live) |=> (rsp_data == RSP_W'($past(sw_open))))
        else $error("live response carries history"); // R9

endmodule

// File: rtl/chassis_intrusion_tracker.sv
// Module: top of the chassis intrusion tracker. Reads the retained
// history each cycle, and writes it back whole when it must change.
// Assumes the external retention cell captures wr_* on a clock edge
// where wr_en is high, and that sw_open is already debounced.
module chassis_intrusion_tracker
    import cit_pkg::*;
#(
    parameter int                CNT_W       = 8,
    parameter logic [BYTE_W-1:0] VALID_MAGIC = 8'hEC,
    parameter logic [BYTE_W-1:0] CLR_MAGIC   = 8'hCE
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_open,
    input  logic               main_pwr,
    input  logic               coin_loss,
    input  logic               cmd_valid,
    input  logic               cmd_live,
    input  logic [BYTE_W-1:0]  cmd_p0,
    input  logic [BYTE_W-1:0]  cmd_p1,
    output logic               rsp_valid,
    output logic [4*CNT_W-1:0] rsp_data,
    input  logic [BYTE_W-1:0]  rd_magic,
    input  logic               rd_ever,
    input  logic               rd_coin,
    input  logic [CNT_W-1:0]   rd_total,
    input  logic [CNT_W-1:0]   rd_offcnt,
    output logic               wr_en,
    output logic [BYTE_W-1:0]  wr_magic,
    output logic               wr_ever,
    output logic               wr_coin,
    output logic [CNT_W-1:0]   wr_total,
    output logic [CNT_W-1:0]   wr_offcnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic     store_ok;
    logic     rise;
    logic     changed;
    cit_act_e act;

    // Storage counts as initialised only with the expected validity byte.
    always_comb store_ok = (rd_magic == VALID_MAGIC);

    cit_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (sw_open),
        .rise  (rise)
    );

    cit_cmd_dec #(
        .CLR_MAGIC (CLR_MAGIC)
    ) u_dec (
        .store_ok  (store_ok),
        .cmd_valid (cmd_valid),
        .cmd_live  (cmd_live),
        .cmd_p0    (cmd_p0),
        .cmd_p1    (cmd_p1),
        .act       (act)
    );

    cit_hist_next #(
        .CNT_W       (CNT_W),
        .VALID_MAGIC (VALID_MAGIC)
    ) u_next (
        .act       (act),
        .rise      (rise),
        .main_pwr  (main_pwr),
        .coin_loss (coin_loss),
        .rd_magic  (rd_magic),
        .rd_ever   (rd_ever),
        .rd_coin   (rd_coin),
        .rd_total  (rd_total),
        .rd_offcnt (rd_offcnt),
        .nx_magic  (wr_magic),
        .nx_ever   (wr_ever),
        .nx_coin   (wr_coin),
        .nx_total  (wr_total),
        .nx_offcnt (wr_offcnt),
        .changed   (changed)
    );

    cit_resp #(
        .CNT_W (CNT_W)
    ) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_live  (cmd_live),
        .sw_open   (sw_open),
        .store_ok  (store_ok),
        .rd_ever   (rd_ever),
        .rd_coin   (rd_coin),
        .rd_total  (rd_total),
        .rd_offcnt (rd_offcnt),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    // Write only out of reset and only when a stored field changes.
    always_comb wr_en = rst_n && changed;

    AST_INIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_magic != VALID_MAGIC) |-> (wr_en && wr_magic == VALID_MAGIC &&
            wr_total == '0 && wr_offcnt == '0 && !wr_ever && !wr_coin))
        else $error("invalid storage not initialised"); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (store_ok && rd_total == CNT_MAX &&
         !(cmd_valid && !cmd_live && cmd_p0 == CLR_MAGIC))
        |-> (wr_total == CNT_MAX))
        else $error("total count wrapped"); // R3
    AST_STICKY_KEEPS_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (store_ok && cmd_valid && !cmd_live && cmd_p0 != CLR_MAGIC &&
         cmd_p1 != '0 && !rise)
        |-> (wr_total == rd_total && wr_offcnt == rd_offcnt &&
             wr_coin >= rd_coin && !wr_ever))
        else $error("sticky clear touched more than the flag"); // R7
    AST_COIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (store_ok && rd_coin && !(cmd_valid && !cmd_live && cmd_p0 == CLR_MAGIC))
        |-> wr_coin)
        else $error("coin flag lost without full clear"); // R4
    AST_OFF_NEEDS_LOW_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        (store_ok && main_pwr && !(cmd_valid && !cmd_live && cmd_p0 == CLR_MAGIC))
        |-> (wr_offcnt == rd_offcnt))
        else $error("powered-off count moved with power on"); // R2

endmodule

// File: tb/chassis_intrusion_tracker_tb.sv
`timescale 1ns/1ps
module chassis_intrusion_tracker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_open = 1'b0, main_pwr = 1'b1, coin_loss = 1'b0;
    logic        cmd_valid = 1'b0, cmd_live = 1'b0;
    logic [7:0]  cmd_p0 = 8'h00, cmd_p1 = 8'h00;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        wr_en, wr_ever, wr_coin;
    logic [7:0]  wr_magic, wr_total, wr_offcnt;

    // Retention cell model: not cleared by rst_n.
    logic [7:0]  m_magic = 8'h00, m_total = 8'h00, m_off = 8'h00;
    logic        m_ever = 1'b0, m_coin = 1'b0;

    int checks = 0, errors = 0;
    int e_ever = 0, e_coin = 0, e_tot = 0, e_off = 0;
    bit done = 0;

    always #2 clk = ~clk;

    chassis_intrusion_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .sw_open(sw_open), .main_pwr(main_pwr),
        .coin_loss(coin_loss), .cmd_valid(cmd_valid), .cmd_live(cmd_live),
        .cmd_p0(cmd_p0), .cmd_p1(cmd_p1), .rsp_valid(rsp_valid),
        .rsp_data(rsp_data), .rd_magic(m_magic), .rd_ever(m_ever),
        .rd_coin(m_coin), .rd_total(m_total), .rd_offcnt(m_off),
        .wr_en(wr_en), .wr_magic(wr_magic), .wr_ever(wr_ever),
        .wr_coin(wr_coin), .wr_total(wr_total), .wr_offcnt(wr_offcnt)
    );

    always @(posedge clk) begin
        if (wr_en) begin
            m_magic <= wr_magic; m_ever <= wr_ever; m_coin <= wr_coin;
            m_total <= wr_total; m_off <= wr_offcnt;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word();
        return {8'(e_off), 8'(e_tot), 7'b0, 1'(e_ever), 7'b0, 1'(e_coin)} ;
    endfunction

    // Expected response word: [7:0] ever, [15:8] coin, [23:16] total, [31:24] off.
    function automatic logic [31:0] exp_hist();
        return {8'(e_off), 8'(e_tot), 7'b0, 1'(e_coin), 7'b0, 1'(e_ever)};
    endfunction

    function automatic logic [31:0] cell_word();
        return {m_off, m_total, 7'b0, m_coin, 7'b0, m_ever};
    endfunction

    task automatic open_once(input logic pwr);
        @(negedge clk); sw_open = 1'b1; main_pwr = pwr;
        @(negedge clk); sw_open = 1'b0; main_pwr = 1'b1;
        @(negedge clk);
        e_ever = 1;
        if (e_tot < 255) e_tot++;
        if (!pwr && e_off < 255) e_off++;
    endtask

    task automatic command(input logic live, input logic [7:0] p0, input logic [7:0] p1,
                           output logic [31:0] rsp, output logic vld);
        @(negedge clk); cmd_valid = 1'b1; cmd_live = live; cmd_p0 = p0; cmd_p1 = p1;
        @(negedge clk); cmd_valid = 1'b0; cmd_live = 1'b0; cmd_p0 = 8'h00; cmd_p1 = 8'h00;
        rsp = rsp_data; vld = rsp_valid;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        logic v;
        // Reset: no writes, no response (R10, R5).
        repeat (4) @(negedge clk);
        check("R10 no write in reset", {31'b0, wr_en}, 32'd0);
        check("R5 no response in reset", {31'b0, rsp_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // Invalid magic initialised in one cycle (R8).
        check("R8 magic written", {24'b0, m_magic}, 32'h0000_00EC);
        check("R8 history zeroed", cell_word(), 32'd0);
        check("R10 idle no write", {31'b0, wr_en}, 32'd0);

        // Pure query changes nothing (R5).
        command(1'b0, 8'h00, 8'h00, r, v);
        check("R5 response valid", {31'b0, v}, 32'd1);
        check("R5 empty history", r, 32'd0);
        @(negedge clk);
        check("R5 response one cycle", {31'b0, rsp_valid}, 32'd0);

        // Sweep of openings, power low on every third one (R1, R2, R3).
        for (int i = 0; i < 300; i++) begin
            open_once(i % 3 != 0);
            if (i % 25 == 24) begin
                command(1'b0, 8'h00, 8'h00, r, v);
                check("R1 R2 sweep query", r, exp_hist());
            end
        end
        check("R3 total saturated", {24'b0, m_total}, 32'd255);
        check("R2 powered-off count", {24'b0, m_off}, 32'd100);

        // Coin pulse (R4), then sticky clear (R7) with pre-command response (R5).
        @(negedge clk); coin_loss = 1'b1;
        @(negedge clk); coin_loss = 1'b0; e_coin = 1;
        check("R4 coin flag set", {31'b0, m_coin}, 32'd1);
        command(1'b0, 8'h00, 8'h01, r, v);
        check("R5 response before sticky clear", r, exp_hist());
        e_ever = 0;
        check("R7 sticky clear only flag", cell_word(), exp_hist());
        check("R4 coin survives sticky clear", {31'b0, m_coin}, 32'd1);

        // Full clear (R6).
        command(1'b0, 8'hCE, 8'h00, r, v);
        check("R5 response before full clear", r, exp_hist());
        e_ever = 0; e_coin = 0; e_tot = 0; e_off = 0;
        check("R6 full clear", cell_word(), 32'd0);

        // Full clear with opening in same cycle, power low (R6).
        open_once(1'b0);
        @(negedge clk); cmd_valid = 1'b1; cmd_p0 = 8'hCE; sw_open = 1'b1; main_pwr = 1'b0;
        @(negedge clk); cmd_valid = 1'b0; cmd_p0 = 8'h00; main_pwr = 1'b1;
        e_ever = 1; e_coin = 0; e_tot = 1; e_off = 1;
        check("R6 event after clear", cell_word(), exp_hist());

        // Held level counts once (R1); live query reports level (R9).
        repeat (6) @(negedge clk);
        check("R1 held level counts once", {24'b0, m_total}, 32'd1);
        command(1'b1, 8'hCE, 8'h01, r, v);
        check("R9 live high", r, 32'd1);
        check("R9 live changes nothing", cell_word(), exp_hist());
        sw_open = 1'b0;
        command(1'b1, 8'h00, 8'h00, r, v);
        check("R9 live low", r, 32'd0);

        // Corrupted magic plus simultaneous opening: init wins (R8).
        @(negedge clk); m_magic = 8'h12; m_total = 8'd7; sw_open = 1'b1;
        @(negedge clk); sw_open = 1'b0;
        e_ever = 0; e_coin = 0; e_tot = 0; e_off = 0;
        check("R8 event dropped at init", cell_word(), 32'd0);
        check("R8 magic restored", {24'b0, m_magic}, 32'h0000_00EC);

        // History query from invalid storage reads zero (R8).
        @(negedge clk); m_magic = 8'h00; m_total = 8'd9; m_ever = 1'b1;
        cmd_valid = 1'b1; cmd_live = 1'b0;
        @(negedge clk); cmd_valid = 1'b0;
        check("R8 invalid storage reads zero", rsp_data, 32'd0);

        // Open level during reset is baseline; storage retained (R1).
        open_once(1'b1);
        @(negedge clk); rst_n = 1'b0; sw_open = 1'b1;
        repeat (3) @(negedge clk);
        check("R10 no write in second reset", {31'b0, wr_en}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        sw_open = 1'b0;
        command(1'b0, 8'h00, 8'h00, r, v);
        check("R1 reset baseline no count", r, exp_hist());

        finish_run();
    end

endmodule